// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Macrocell

This block is one output cell of a programmable sum-of-products logic device. Eight product terms from the AND array come into the cell. From them, and from a small configuration word, the cell builds the value driven onto its pin, the tristate enable for that pin and the signal fed back into the array. The configuration can make the cell a clocked registered output, a combinational I/O whose enable comes from one of its own product terms, an always-driven combinational output, or a pure input. A per-cell polarity bit sets whether the pin is active high or active low.

The configuration enters through a serial shift port and becomes active only on a load strobe. It can be read back one byte at a time together with a 16-bit checksum. One configuration bit is a security bit. Once it has been committed, it hides the control byte from readback until the next reset. The signature bytes and the checksum stay readable. Reset clears the configuration and the cell register, so a registered pin comes up high.

Top module: `omc_macrocell`

## Requirements
- R1: During and after reset the cell register holds 0 and the registered pin reads 1. This holds whatever polarity was programmed before the reset. Reset clears the configuration to the all-zero registered mode, and with oe_n low the pin is then enabled.
- R2: Registered mode (control bit0 SYN=0, bit2 AC1=0) ORs all eight product terms, pt[7] included. One clock edge later pin_out shows the polarity-adjusted sum. fb equals pin_out, because it is the inverted register output.
- R3: In registered mode pin_oe is the inverse of the shared active-low oe_n input.
- R4: Combinational I/O mode is selected by SYN=1 with AC0 (bit1) = 1, or by SYN=0 with AC1=1. In this mode pin_out is the polarity-adjusted OR of pt[6:0], pin_oe equals pt[7], pt[7] has no effect on pin_out, and fb is pin_in.
- R5: SYN=1, AC0=0, AC1=0 gives an always-enabled combinational output from all eight terms, with fb equal to pin_out.
- R6: SYN=1, AC0=0, AC1=1 makes the cell a dedicated input: pin_oe is 0, pin_out is 0 and fb follows pin_in.
- R7: When the fixed-output flag (bit4) is set, the dedicated-input request of R6 is ignored and the cell behaves as in R5.
- R8: The polarity bit (bit3) set to 1 makes the pin active high (the pin equals the sum). Set to 0, it makes the pin active low (the pin equals the inverted sum).
- R9: With cfg_shift high, cfg_sdi enters at bit 0 of the shadow word on each clock edge. The first bit sent ends at the top bit. The word holds the control byte at bits 7:0 and signature byte k at bits 8k+7:8k. A cfg_load pulse copies the shadow word to the active configuration. Shifting without a load changes neither the cell behaviour nor the readback.
- R10: Committing a word with the security bit (bit5) set makes rd_addr 0 read 0x00 until reset, even across later loads. Signature bytes (addresses 1..2) and the checksum stay readable.
- R11: rd_addr 3 and 4 return the low and high bytes of the modulo-65536 sum of all active configuration bytes, the signature included. rd_addr 0 returns the control byte when the cell is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the cell register and the configuration logic |
| rst_n | input | 1 | Active-low synchronous power-up reset |
| pt | input | 8 | Product terms from the AND array |
| oe_n | input | 1 | Shared active-low output enable for registered cells |
| pin_in | input | 1 | Level sensed on the cell's pin |
| cfg_sdi | input | 1 | Serial configuration data |
| cfg_shift | input | 1 | Shift strobe for the configuration shadow word |
| cfg_load | input | 1 | Commit strobe: shadow word becomes active |
| rd_addr | input | 3 | Readback byte select |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Tristate enable of the pin driver |
| fb | output | 1 | Feedback into the AND array |
| rd_data | output | 8 | Readback byte |

## Verification
The bench checks that pt[7] counts in the registered sum but not in the combinational I/O sum. A design that mixed up the term allocation would show the wrong pin level in exactly one of the two cases. It sends a dedicated-input request to a cell that has the fixed-output flag set; a design that ignored the flag would release the pin and feed back pin_in instead. It checks that the registered pin reads high after a reset that follows an active-high configuration, that a shifted but uncommitted word leaves everything unchanged, and that the lock survives a reload with the security bit clear. Checksum values with byte carries catch a sum truncated to eight bits or one that leaves out the signature.

// File: rtl/omc_pkg.sv
package omc_pkg;

  typedef enum logic [1:0] {
    MODE_REG = 2'd0,
    MODE_IO  = 2'd1,
    MODE_OUT = 2'd2,
    MODE_IN  = 2'd3
  } cell_mode_e;

  // control byte bit positions
  localparam int CTL_SYN   = 0;
  localparam int CTL_AC0   = 1;
  localparam int CTL_AC1   = 2;
  localparam int CTL_POL   = 3;
  localparam int CTL_FIX   = 4;
  localparam int CTL_SEC   = 5;
  localparam int CTL_OUT_W = 5;

  function automatic cell_mode_e decode_mode(input logic syn, input logic ac0,
                                             input logic ac1, input logic fixed);
    cell_mode_e m;
    if (!syn)               m = ac1 ? MODE_IO : MODE_REG;
    else if (ac0)           m = MODE_IO;
    else if (ac1 && !fixed) m = MODE_IN;
    else                    m = MODE_OUT;
    return m;
  endfunction

  function automatic logic apply_pol(input logic s, input logic active_high);
    return active_high ? s : ~s;
  endfunction

endpackage

// File: rtl/omc_cfg_store.sv
module omc_cfg_store #(
  parameter int NB = 3,
  parameter int AW = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sdi,
  input  logic                           shift,
  input  logic                           load,
  input  logic [AW-1:0]                  rd_addr,
  output logic [omc_pkg::CTL_OUT_W-1:0]  ctl,
  output logic                           locked,
  output logic [7:0]                     rd_data
);
  import omc_pkg::*;

  localparam int W = 8 * NB;
  localparam logic [AW-1:0] ADDR_LO = AW'(NB);
  localparam logic [AW-1:0] ADDR_HI = AW'(NB + 1);

  logic [W-1:0] shadow;
  logic [W-1:0] active;
  logic [7:0]   cfg_byte [NB];
  logic [15:0]  cks;

  function automatic logic [15:0] byte_sum(input logic [W-1:0] v);
    logic [15:0] acc;
    acc = '0;
    for (int k = 0; k < NB; k++) acc = acc + {8'h00, v[8*k +: 8]};
    return acc;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
      locked <= 1'b0;
    end else if (load) begin
      active <= shadow;
      locked <= locked | shadow[CTL_SEC];
    end else if (shift) begin
      shadow <= {shadow[W-2:0], sdi};
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_bytes
    assign cfg_byte[g] = active[8*g +: 8];
  end

  assign cks = byte_sum(active);
  assign ctl = active[CTL_OUT_W-1:0];

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == '0) rd_data = locked ? 8'h00 : cfg_byte[0];
    for (int k = 1; k < NB; k++)
      if (rd_addr == AW'(k)) rd_data = cfg_byte[k];
    if (rd_addr == ADDR_LO) rd_data = cks[7:0];
    if (rd_addr == ADDR_HI) rd_data = cks[15:8];
  end

endmodule

// File: rtl/omc_mode_dec.sv
module omc_mode_dec (
  input  logic                syn,
  input  logic                ac0,
  input  logic                ac1,
  input  logic                fixed,
  output omc_pkg::cell_mode_e mode
);
  assign mode = omc_pkg::decode_mode(syn, ac0, ac1, fixed);
endmodule

// File: rtl/omc_datapath.sv
module omc_datapath #(
  parameter int NPT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPT-1:0]      pt,
  input  logic                pol,
  input  omc_pkg::cell_mode_e mode,
  input  logic                oe_n,
  input  logic                pin_in,
  output logic                pin_out,
  output logic                pin_oe,
  output logic                fb,
  output logic                q
);
  import omc_pkg::*;

  localparam int IO_TERMS = NPT - 1;

  logic sum_full;
  logic sum_io;
  logic d_in;

  assign sum_full = |pt;
  assign sum_io   = |pt[IO_TERMS-1:0];
  // register sits ahead of an inverting buffer
  assign d_in     = ~apply_pol(sum_full, pol);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d_in;
  end

  always_comb begin
    unique case (mode)
      MODE_REG: begin
        pin_out = ~q;
        pin_oe  = ~oe_n;
        fb      = ~q;
      end
      MODE_IO: begin
        pin_out = apply_pol(sum_io, pol);
        pin_oe  = pt[NPT-1];
        fb      = pin_in;
      end
      MODE_OUT: begin
        pin_out = apply_pol(sum_full, pol);
        pin_oe  = 1'b1;
        fb      = apply_pol(sum_full, pol);
      end
      default: begin
        pin_out = 1'b0;
        pin_oe  = 1'b0;
        fb      = pin_in;
      end
    endcase
  end

endmodule

// File: rtl/omc_macrocell.sv
module omc_macrocell #(
  parameter int NPT       = 8,
  parameter int SIG_BYTES = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NPT-1:0]                      pt,
  input  logic                                oe_n,
  input  logic                                pin_in,
  input  logic                                cfg_sdi,
  input  logic                                cfg_shift,
  input  logic                                cfg_load,
  input  logic [$clog2(SIG_BYTES + 3)-1:0]    rd_addr,
  output logic                                pin_out,
  output logic                                pin_oe,
  output logic                                fb,
  output logic [7:0]                          rd_data
);
  import omc_pkg::*;

  localparam int NB = 1 + SIG_BYTES;
  localparam int AW = $clog2(NB + 2);

  logic [CTL_OUT_W-1:0] ctl;
  logic                 locked;
  logic                 cfg_syn, cfg_ac0, cfg_ac1, cfg_pol, cfg_fixed;
  cell_mode_e           mode;
  logic                 q;

  omc_cfg_store #(.NB(NB), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .sdi(cfg_sdi), .shift(cfg_shift),
    .load(cfg_load), .rd_addr(rd_addr), .ctl(ctl), .locked(locked),
    .rd_data(rd_data)
  );

  assign cfg_syn   = ctl[CTL_SYN];
  assign cfg_ac0   = ctl[CTL_AC0];
  assign cfg_ac1   = ctl[CTL_AC1];
  assign cfg_pol   = ctl[CTL_POL];
  assign cfg_fixed = ctl[CTL_FIX];

  omc_mode_dec u_dec (
    .syn(cfg_syn), .ac0(cfg_ac0), .ac1(cfg_ac1), .fixed(cfg_fixed), .mode(mode)
  );

  omc_datapath #(.NPT(NPT)) u_dp (
    .clk(clk), .rst_n(rst_n), .pt(pt), .pol(cfg_pol), .mode(mode),
    .oe_n(oe_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .fb(fb), .q(q)
  );

endmodule

// File: rtl/omc_macrocell_chk.sv
module omc_macrocell_chk #(
  parameter int NPT = 8,
  parameter int AW  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NPT-1:0]      pt,
  input logic                oe_n,
  input logic                pin_in,
  input logic                pin_out,
  input logic                pin_oe,
  input logic                fb,
  input omc_pkg::cell_mode_e mode,
  input logic                cfg_syn,
  input logic                cfg_ac0,
  input logic                cfg_ac1,
  input logic                cfg_pol,
  input logic                cfg_fixed,
  input logic                locked,
  input logic [AW-1:0]       rd_addr,
  input logic [7:0]          rd_data,
  input logic                q
);
  import omc_pkg::*;

  // R1
  reset_reg_low_chk: assert property (@(posedge clk) !rst_n |=> (!q && !locked));

  // R2
  reg_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_REG) ##1 (mode == MODE_REG) |->
      (pin_out == ($past(cfg_pol) ? $past(|pt) : !$past(|pt))) && (fb == pin_out));

  // R3
  reg_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_REG) |-> (pin_oe == !oe_n));

  // R4
  io_oe_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IO) |-> (pin_oe == pt[NPT-1]) && (fb == pin_in));

  // R5
  out_always_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OUT) |-> pin_oe && (fb == pin_out));

  // R6
  input_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IN) |-> !pin_oe && (fb == pin_in));

  // R7
  fixed_never_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fixed && cfg_syn && !cfg_ac0 && cfg_ac1) |-> (mode == MODE_OUT));

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R10
  lock_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && rd_addr == '0) |-> (rd_data == 8'h00));

endmodule

bind omc_macrocell omc_macrocell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pt(pt), .oe_n(oe_n), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb), .mode(mode),
  .cfg_syn(cfg_syn), .cfg_ac0(cfg_ac0), .cfg_ac1(cfg_ac1), .cfg_pol(cfg_pol),
  .cfg_fixed(cfg_fixed), .locked(locked), .rd_addr(rd_addr),
  .rd_data(rd_data), .q(q)
);

// File: tb/tb_omc_macrocell.sv
`timescale 1ns/1ps
module tb_omc_macrocell;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pt = 8'h00;
  logic       oe_n = 1'b0;
  logic       pin_in = 1'b0;
  logic       cfg_sdi = 1'b0;
  logic       cfg_shift = 1'b0;
  logic       cfg_load = 1'b0;
  logic [2:0] rd_addr = 3'd0;
  logic       pin_out, pin_oe, fb;
  logic [7:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  omc_macrocell dut (
    .clk(clk), .rst_n(rst_n), .pt(pt), .oe_n(oe_n), .pin_in(pin_in),
    .cfg_sdi(cfg_sdi), .cfg_shift(cfg_shift), .cfg_load(cfg_load),
    .rd_addr(rd_addr), .pin_out(pin_out), .pin_oe(pin_oe), .fb(fb),
    .rd_data(rd_data)
  );

  // {req, ctrl, pt, oe_n, pin_in, exp_pin, exp_oe, exp_fb}
  localparam logic [24:0] VEC [0:14] = '{
    {4'd2, 8'h08, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 reg, sum 0
    {4'd2, 8'h08, 8'h80, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R2 pt7 counts
    {4'd3, 8'h08, 8'h01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R3 oe_n high
    {4'd8, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R8 active low
    {4'd8, 8'h00, 8'h10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 active low
    {4'd4, 8'h0B, 8'h80, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 pt7 only enables
    {4'd4, 8'h0B, 8'h02, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4
    {4'd4, 8'h03, 8'h40, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 active low
    {4'd4, 8'h04, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 via SYN=0 AC1=1
    {4'd5, 8'h09, 8'h80, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R5
    {4'd5, 8'h01, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R5 active low
    {4'd6, 8'h05, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R6
    {4'd6, 8'h05, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    {4'd7, 8'h15, 8'h04, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 request ignored
    {4'd7, 8'h1D, 8'h04, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}  // R7 active high
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_word(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      @(negedge clk); cfg_shift = 1'b1; cfg_sdi = w[i];
    end
    @(negedge clk); cfg_shift = 1'b0;
  endtask

  task automatic commit();
    cfg_load = 1'b1;
    @(negedge clk); cfg_load = 1'b0;
  endtask

  task automatic load_cfg(input logic [7:0] ctrl, input logic [7:0] s1, input logic [7:0] s2);
    shift_word({s2, s1, ctrl});
    commit();
  endtask

  task automatic read_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    rd_addr = a; #1;
    check(req, {8'h00, rd_data}, {8'h00, exp});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] cur;
    logic [15:0] sum;
    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    check("R1 pin in reset", {15'd0, pin_out}, 16'd1);
    check("R1 oe in reset", {15'd0, pin_oe}, 16'd1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 pin after reset", {14'd0, pin_out, fb}, 16'd3);
    read_chk("R1 ctrl cleared", 3'd0, 8'h00);
    read_chk("R11 cks cleared", 3'd3, 8'h00);

    // table walk
    cur = 8'h00;
    foreach (VEC[i]) begin
      if (VEC[i][20:13] != cur) begin
        @(negedge clk);
        load_cfg(VEC[i][20:13], 8'h00, 8'h00);
        cur = VEC[i][20:13];
      end
      @(negedge clk);
      pt = VEC[i][12:5]; oe_n = VEC[i][4]; pin_in = VEC[i][3];
      @(negedge clk); #1;
      check($sformatf("R%0d vec%0d pin", VEC[i][24:21], i), {15'd0, pin_out}, {15'd0, VEC[i][2]});
      check($sformatf("R%0d vec%0d oe", VEC[i][24:21], i), {15'd0, pin_oe}, {15'd0, VEC[i][1]});
      check($sformatf("R%0d vec%0d fb", VEC[i][24:21], i), {15'd0, fb}, {15'd0, VEC[i][0]});
    end

    // R1: registered pin high after reset even with active-high programming
    @(negedge clk);
    load_cfg(8'h08, 8'h00, 8'h00);
    pt = 8'h00; oe_n = 1'b0;
    @(negedge clk); #1;
    check("R1 pre-reset pin low", {15'd0, pin_out}, 16'd0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #1;
    check("R1 pin high in reset", {15'd0, pin_out}, 16'd1);
    @(negedge clk); rst_n = 1'b1;

    // R9: shifting without commit has no effect
    @(negedge clk);
    load_cfg(8'h0B, 8'h00, 8'h00);
    pt = 8'h02; pin_in = 1'b0;
    read_chk("R9 ctrl readback", 3'd0, 8'h0B);
    shift_word({8'h00, 8'h00, 8'h05});
    #1;
    check("R9 no commit pin", {14'd0, pin_out, pin_oe}, 16'd2);
    read_chk("R9 no commit readback", 3'd0, 8'h0B);
    @(negedge clk); commit(); #1;
    check("R9 commit pin", {14'd0, pin_out, pin_oe}, 16'd0);
    read_chk("R9 commit readback", 3'd0, 8'h05);

    // R11 checksum
    @(negedge clk);
    load_cfg(8'h08, 8'h12, 8'h34);
    sum = 16'h0008 + 16'h0012 + 16'h0034;
    read_chk("R11 sig1", 3'd1, 8'h12);
    read_chk("R11 sig2", 3'd2, 8'h34);
    read_chk("R11 cks lo", 3'd3, sum[7:0]);
    read_chk("R11 cks hi", 3'd4, sum[15:8]);
    @(negedge clk);
    load_cfg(8'hC0, 8'hFF, 8'hFF);
    sum = 16'h00C0 + 16'h00FF + 16'h00FF;
    read_chk("R11 carry lo", 3'd3, sum[7:0]);
    read_chk("R11 carry hi", 3'd4, sum[15:8]);

    // R10 security
    @(negedge clk);
    load_cfg(8'h28, 8'hAA, 8'h55);
    sum = 16'h0028 + 16'h00AA + 16'h0055;
    read_chk("R10 ctrl hidden", 3'd0, 8'h00);
    read_chk("R10 sig1 visible", 3'd1, 8'hAA);
    read_chk("R10 sig2 visible", 3'd2, 8'h55);
    read_chk("R10 cks lo", 3'd3, sum[7:0]);
    read_chk("R10 cks hi", 3'd4, sum[15:8]);
    @(negedge clk);
    load_cfg(8'h08, 8'h00, 8'h00);
    read_chk("R10 lock survives reload", 3'd0, 8'h00);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    load_cfg(8'h08, 8'h00, 8'h00);
    read_chk("R10 unlocked after reset", 3'd0, 8'h08);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule